// File: doc/BRIEF.md
# Full-Raster Active-Video Stripper

This block takes a video stream that carries the complete raster, blanking included, several pixels per beat, and turns it into a stream that carries only the visible pixels. Each input lane holds one pixel next to a one-bit flag that says whether the pixel belongs to the visible picture. Beats without visible pixels produce no output beat. The flags are dropped from the output, so the output lanes hold pixel data only.

A high input `in_tuser` marks a blanking beat that opens a new field. The block remembers that mark and places it on the first output beat it sends afterwards. That beat always starts with the first visible pixel of the field in lane 0. Because a line may start in any input lane, a barrel shifter packs the visible pixels into full output beats. Pixels left over from one beat are carried to the next. When a run of visible pixels ends, a partly filled carry is sent out as a short beat, with the unused upper lanes set to zero. The block passes back-pressure straight through: the input is accepted exactly when the output is ready. The output has no latency of its own.

Top module: `fr_raster_stripper`

## Requirements
- R1: After reset the carry buffer is empty and no start-of-field mark is pending. A full visible beat sent before any `in_tuser` comes out unchanged with `out_tuser` low.
- R2: Input lane i occupies `in_tdata[i*(PIX_W+1) +: PIX_W+1]`. Its pixel is in the low PIX_W bits and its visible flag is the top bit (1 = visible). Output lane i occupies `out_tdata[i*PIX_W +: PIX_W]`.
- R3: A beat with no visible lane, accepted while the carry is empty, gives `out_tvalid` low.
- R4: On a beat with `in_tuser` high, all visible flags are ignored, no pixel is taken, and a start-of-field mark becomes pending.
- R5: While a mark is pending, the next output beat carries `out_tuser` high. The mark then clears, and every other output beat has `out_tuser` low.
- R6: The first visible pixel after a start-of-field mark comes out in lane 0 of the beat that carries `out_tuser`, whatever input lane it arrived in.
- R7: Visible pixels leave in arrival order with no gaps. Visible lanes within one input beat are contiguous. Every output beat except a flush beat holds PIXELS_PER_CLK pixels.
- R8: A beat with no visible lane, accepted while the carry holds pixels, sends those pixels from lane 0 upward with zeros above them, and empties the carry.
- R9: `in_tready` equals `out_tready`. While `out_tready` is low nothing is consumed and no state changes.
- R10: `out_tvalid` is high only while `in_tvalid` is high.
- R11: When a start-of-field beat arrives with pixels still in the carry, that beat flushes the previous field's tail with `out_tuser` low and still sets the new mark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_tvalid | input | 1 | Input beat valid |
| in_tready | output | 1 | Input beat accepted |
| in_tdata | input | PIXELS_PER_CLK*(BITS_PER_PIXEL+1) | Pixels, each with its visible flag |
| in_tuser | input | 1 | Blanking beat that opens a field |
| out_tvalid | output | 1 | Output beat valid |
| out_tready | input | 1 | Downstream ready |
| out_tdata | output | PIXELS_PER_CLK*BITS_PER_PIXEL | Packed visible pixels |
| out_tuser | output | 1 | First beat of a field |

## Verification
The case where two functions meet in one cycle is a start-of-field beat that arrives while the carry still holds the previous line's tail. That single beat must flush the old pixels with `out_tuser` low and also arm the new mark. The bench provokes this by ending active runs at a lane that is not a multiple of the beat width and starting the next frame with no blanking beat in between. A queue model judges the result: the flushed lanes, their zero fill and the low `out_tuser` are checked on that beat. The next full beat must then carry `out_tuser` with the new field's first pixel in lane 0.

// File: rtl/fr_strip_pkg.sv
package fr_strip_pkg;

  // What an accepted input beat does to the output side.
  typedef enum logic [1:0] {
    BK_IDLE  = 2'd0,  // nothing visible, carry empty: no output
    BK_HOLD  = 2'd1,  // visible pixels absorbed, not yet a full beat
    BK_PACK  = 2'd2,  // a full packed beat leaves
    BK_FLUSH = 2'd3   // carry tail leaves, zero padded
  } beat_kind_e;

endpackage

// File: rtl/fr_lane_decode.sv
module fr_lane_decode #(
  parameter int LANES = 4,
  parameter int PIX_W = 8,
  localparam int SLOT_W = PIX_W + 1,
  localparam int IDX_W  = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int CNT_W  = $clog2(2 * LANES + 1)
) (
  input  logic [LANES*SLOT_W-1:0] raw_data,
  input  logic                    blank_mark,
  output logic [LANES*PIX_W-1:0]  pix_vec,
  output logic [IDX_W-1:0]        vis_start,
  output logic [CNT_W-1:0]        vis_count
);

  logic [LANES-1:0] vis_mask;

  // Lowest visible lane, 0 when none is visible.
  function automatic logic [IDX_W-1:0] lowest_lane(input logic [LANES-1:0] m);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int k = LANES - 1; k >= 0; k--) begin
      if (m[k]) r = IDX_W'(k);
    end
    return r;
  endfunction

  function automatic logic [CNT_W-1:0] lane_total(input logic [LANES-1:0] m);
    logic [CNT_W-1:0] c;
    c = '0;
    for (int k = 0; k < LANES; k++) c = c + CNT_W'(m[k]);
    return c;
  endfunction

  // Split each slot into pixel and flag; a field-start beat carries no pixels (R4).
  for (genvar g = 0; g < LANES; g++) begin : g_slot
    assign pix_vec[g*PIX_W +: PIX_W] = raw_data[g*SLOT_W +: PIX_W];
    assign vis_mask[g] = raw_data[g*SLOT_W + PIX_W] & ~blank_mark;
  end

  assign vis_start = lowest_lane(vis_mask);
  assign vis_count = lane_total(vis_mask);

endmodule

// File: rtl/fr_lane_packer.sv
module fr_lane_packer #(
  parameter int LANES = 4,
  parameter int PIX_W = 8,
  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int CNT_W = $clog2(2 * LANES + 1),
  localparam int BEAT_W = LANES * PIX_W,
  localparam int WIDE_W = 2 * BEAT_W
) (
  input  logic [BEAT_W-1:0] carry_vec,
  input  logic [CNT_W-1:0]  carry_cnt,
  input  logic [BEAT_W-1:0] pix_vec,
  input  logic [IDX_W-1:0]  vis_start,
  input  logic [CNT_W-1:0]  vis_count,
  output logic [WIDE_W-1:0] merged,
  output logic [CNT_W-1:0]  merged_cnt
);

  logic [WIDE_W-1:0] aligned;
  logic [WIDE_W-1:0] placed;

  // Shift distances in bits, kept as functions so a model can restate them.
  function automatic int drop_bits(input logic [IDX_W-1:0] s);
    return int'(s) * PIX_W;
  endfunction

  function automatic int append_bits(input logic [CNT_W-1:0] c);
    return int'(c) * PIX_W;
  endfunction

  always_comb begin
    // Move the first visible lane down to lane 0 and drop the lanes above the run.
    aligned = WIDE_W'(pix_vec) >> drop_bits(vis_start);
    for (int j = 0; j < LANES; j++) begin
      if (j >= int'(vis_count)) aligned[j*PIX_W +: PIX_W] = '0;
    end
    // Put the new pixels right after the carried ones.
    placed = aligned << append_bits(carry_cnt);
    merged = WIDE_W'(carry_vec) | placed;
  end

  assign merged_cnt = carry_cnt + vis_count;

endmodule

// File: rtl/fr_sof_hold.sv
module fr_sof_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic take,        // input beat accepted
  input  logic field_start, // accepted beat opens a field
  input  logic beat_out,    // accepted beat produces an output beat
  output logic sof_pend
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sof_pend <= 1'b0;
    end else if (take && field_start) begin
      sof_pend <= 1'b1;
    end else if (take && beat_out) begin
      sof_pend <= 1'b0;
    end
  end

  assert_sof_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && field_start) |=> sof_pend);

  assert_sof_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && beat_out && !field_start) |=> !sof_pend);

  assert_sof_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(sof_pend));

endmodule

// File: rtl/fr_raster_stripper.sv
module fr_raster_stripper
  import fr_strip_pkg::*;
#(
  parameter int PIXELS_PER_CLK = 4,
  parameter int BITS_PER_PIXEL = 8,
  localparam int SLOT_W = BITS_PER_PIXEL + 1,
  localparam int IDX_W  = (PIXELS_PER_CLK > 1) ? $clog2(PIXELS_PER_CLK) : 1,
  localparam int CNT_W  = $clog2(2 * PIXELS_PER_CLK + 1),
  localparam int BEAT_W = PIXELS_PER_CLK * BITS_PER_PIXEL,
  localparam int WIDE_W = 2 * BEAT_W
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               in_tvalid,
  output logic                               in_tready,
  input  logic [PIXELS_PER_CLK*SLOT_W-1:0]   in_tdata,
  input  logic                               in_tuser,
  output logic                               out_tvalid,
  input  logic                               out_tready,
  output logic [BEAT_W-1:0]                  out_tdata,
  output logic                               out_tuser
);

  logic [BEAT_W-1:0] pix_vec;
  logic [IDX_W-1:0]  vis_start;
  logic [CNT_W-1:0]  vis_count;
  logic [BEAT_W-1:0] carry_vec;
  logic [CNT_W-1:0]  carry_cnt;
  logic [WIDE_W-1:0] merged;
  logic [CNT_W-1:0]  merged_cnt;
  logic              sof_pend;
  beat_kind_e        kind;

  // Named events for the checks below.
  logic take;
  logic emits;
  logic full_beat;

  fr_lane_decode #(.LANES(PIXELS_PER_CLK), .PIX_W(BITS_PER_PIXEL)) decode_i (
    .raw_data   (in_tdata),
    .blank_mark (in_tuser),
    .pix_vec    (pix_vec),
    .vis_start  (vis_start),
    .vis_count  (vis_count)
  );

  fr_lane_packer #(.LANES(PIXELS_PER_CLK), .PIX_W(BITS_PER_PIXEL)) packer_i (
    .carry_vec  (carry_vec),
    .carry_cnt  (carry_cnt),
    .pix_vec    (pix_vec),
    .vis_start  (vis_start),
    .vis_count  (vis_count),
    .merged     (merged),
    .merged_cnt (merged_cnt)
  );

  assign full_beat = merged_cnt >= CNT_W'(PIXELS_PER_CLK);

  always_comb begin
    if (vis_count != '0) begin
      kind = full_beat ? BK_PACK : BK_HOLD;
    end else begin
      kind = (carry_cnt != '0) ? BK_FLUSH : BK_IDLE;
    end
  end

  assign emits      = (kind == BK_PACK) || (kind == BK_FLUSH);
  assign in_tready  = out_tready;
  assign take       = in_tvalid && out_tready;
  assign out_tvalid = in_tvalid && emits;
  assign out_tdata  = merged[BEAT_W-1:0];
  assign out_tuser  = out_tvalid && sof_pend;

  fr_sof_hold sof_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .take        (take),
    .field_start (in_tuser),
    .beat_out    (emits),
    .sof_pend    (sof_pend)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      carry_vec <= '0;
      carry_cnt <= '0;
    end else if (take) begin
      unique case (kind)
        BK_PACK: begin
          carry_vec <= merged[WIDE_W-1 -: BEAT_W];
          carry_cnt <= merged_cnt - CNT_W'(PIXELS_PER_CLK);
        end
        BK_HOLD: begin
          carry_vec <= merged[BEAT_W-1:0];
          carry_cnt <= merged_cnt;
        end
        BK_FLUSH: begin
          carry_vec <= '0;
          carry_cnt <= '0;
        end
        default: begin
          carry_vec <= carry_vec;
          carry_cnt <= carry_cnt;
        end
      endcase
    end
  end

  assert_carry_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (carry_cnt < CNT_W'(PIXELS_PER_CLK)));

  assert_flush_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (take && kind == BK_FLUSH) |=> (carry_cnt == '0));

  assert_field_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_tuser) |=> (carry_cnt == '0));

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> ($stable(carry_cnt) && $stable(carry_vec)));

  assert_valid_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_tvalid |-> in_tvalid);

  assert_tail_no_mark_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (take && kind == BK_FLUSH && in_tuser) |=> sof_pend);

endmodule

// File: tb/fr_raster_stripper_tb.sv
module fr_raster_stripper_tb_top;

  localparam int L = 4;
  localparam int W = 8;
  localparam int SW = W + 1;
  localparam int CLK_PERIOD = 10;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           in_tvalid = 1'b0;
  logic           in_tready;
  logic [L*SW-1:0] in_tdata = '0;
  logic           in_tuser = 1'b0;
  logic           out_tvalid;
  logic           out_tready = 1'b1;
  logic [L*W-1:0] out_tdata;
  logic           out_tuser;

  fr_raster_stripper #(.PIXELS_PER_CLK(L), .BITS_PER_PIXEL(W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_tvalid(in_tvalid), .in_tready(in_tready), .in_tdata(in_tdata), .in_tuser(in_tuser),
    .out_tvalid(out_tvalid), .out_tready(out_tready), .out_tdata(out_tdata), .out_tuser(out_tuser)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;
  logic [W-1:0] q[$];   // model of carried pixels
  bit pend_m = 0;       // model of pending field mark

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Pack the first L model pixels (zero where missing) into an output beat (R2 layout).
  function automatic logic [L*W-1:0] pack_beat(input logic [W-1:0] src[$]);
    logic [L*W-1:0] v;
    v = '0;
    for (int k = 0; k < L; k++) if (k < src.size()) v[k*W +: W] = src[k];
    return v;
  endfunction

  // One input beat: lanes s..s+n-1 visible (ignored when tu). Stalls first.
  task automatic beat(input bit tu, input int s, input int n, input int stalls);
    logic [W-1:0] tmp[$];
    logic [W-1:0] px;
    bit ev, eu, fl;
    logic [L*W-1:0] ed;
    int act_n;
    tmp = q;
    for (int i = 0; i < L; i++) begin
      px = W'($urandom);
      in_tdata[i*SW +: W] = px;
      in_tdata[i*SW + W] = tu ? 1'($urandom) : (i >= s && i < s + n);
      if (!tu && i >= s && i < s + n) tmp.push_back(px);
    end
    in_tuser = tu;
    in_tvalid = 1'b1;
    act_n = tu ? 0 : n;
    fl = (act_n == 0) && (q.size() > 0);
    ev = fl || (act_n > 0 && tmp.size() >= L);
    eu = ev && pend_m;
    ed = ev ? pack_beat(tmp) : '0;
    for (int k = 0; k < stalls; k++) begin
      out_tready = 1'b0;
      #1;
      chk("R9 tready", in_tready, 0);
      chk("R9 valid in stall", out_tvalid, ev);
      @(negedge clk);
    end
    out_tready = 1'b1;
    #1;
    chk("R9 tready", in_tready, 1);
    if (fl) chk(tu ? "R11 valid" : "R8 valid", out_tvalid, 1);
    else if (ev) chk(eu ? "R5 valid" : "R7 valid", out_tvalid, 1);
    else chk(tu ? "R4 valid" : "R3 valid", out_tvalid, 0);
    if (ev) begin
      chk(eu ? "R6 data" : (fl ? "R8 data" : "R7 data"), out_tdata, ed);
      chk(tu ? "R11 tuser" : "R5 tuser", out_tuser, eu);
    end
    // Advance the model.
    if (fl) q.delete();
    else if (ev) begin
      for (int k = 0; k < L; k++) void'(tmp.pop_front());
      q = tmp;
    end else q = tmp;
    if (tu) pend_m = 1;
    else if (ev) pend_m = 0;
    @(negedge clk);
    in_tvalid = 1'b0;
  endtask

  task automatic idle_check();
    in_tvalid = 1'b0;
    in_tdata = {L*SW{1'b1}};
    #1;
    chk("R10 no input", out_tvalid, 0);
    @(negedge clk);
  endtask

  function automatic int rstall();
    return ($urandom % 4 == 0) ? 1 + int'($urandom % 2) : 0;
  endfunction

  // A visible run of P pixels starting at lane s.
  task automatic run(input int s, input int P);
    int left, ln, st;
    left = P;
    st = s;
    while (left > 0) begin
      ln = (L - st < left) ? L - st : left;
      beat(0, st, ln, rstall());
      left -= ln;
      st = 0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk("R1 reset valid", out_tvalid, 0);
    chk("R1 reset tready", in_tready, 1);
    @(negedge clk);
    // R1: aligned full beat before any field mark passes with tuser low.
    beat(0, 0, L, 0);
    idle_check();
    // R4/R6: field start, single pixel in top lane, then flush (R8).
    beat(1, 0, L, 0);
    beat(0, L - 1, 1, 0);
    beat(0, 0, 0, 0);
    // R6: field start, run from lane 2 long enough for full beats.
    beat(1, 0, 0, 0);
    run(2, 9);
    // R11: tail still carried, next frame begins at once.
    beat(1, 0, 0, 1);
    run(1, 7);
    beat(0, 0, 0, 2);
    beat(0, 0, 0, 0);  // R3: nothing carried, nothing visible
    // Constrained random frames.
    for (int f = 0; f < 60; f++) begin
      repeat ($urandom % 2 + 1) beat(1, 0, 0, rstall());
      repeat ($urandom % 3) beat(0, 0, 0, rstall());
      for (int ln = 0; ln < 1 + int'($urandom % 3); ln++) begin
        run(int'($urandom % L), 1 + int'($urandom % 14));
        repeat ($urandom % 3) beat(0, 0, 0, rstall());
      end
      if ($urandom % 5 == 0) idle_check();
    end
    beat(0, 0, 0, 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule